// File: doc/BRIEF.md
# Tag-Renaming Operation Station Bank

This block is a small pool of holding stations placed in front of one class of execution unit in an out-of-order core. The issue stage hands it an operation and two source operands. Each operand is either a ready value or the tag of the station, in this bank or another one, that will produce it. A tag of zero always means the value is present. Because a waiting operand names the station that produces it and not an architectural register, later writes to the same register cannot disturb it. This removes write-after-read and write-after-write stalls.

Every station listens to a shared result broadcast bus, which carries a valid bit, a tag and a value. A station that is waiting for that tag copies the value. A station whose two operands are both present competes for the unit. In each cycle the earliest-issued competitor is sent out with its operation, its two values and its own tag. The station then stays occupied until its own tag appears on the broadcast bus, because the unit's finished result goes out under that tag. When that happens the slot becomes free again.

The stations of this bank own the tags BASE_TAG to BASE_TAG+NUM_RS-1. Slot i owns tag BASE_TAG+i. All other non-zero tags belong to producers outside the bank.

Top module: `rs_bank`

## Requirements
- R1: `iss_full` is 1 exactly when all NUM_RS stations are occupied. An issue is accepted at a rising edge when `iss_valid` is 1 and `iss_full` is 0. An issue request made while `iss_full` is 1 changes nothing.
- R2: An accepted issue goes into the lowest-numbered free slot. While `iss_full` is 0, `iss_tag` shows BASE_TAG plus the index of that slot, which is the tag the new entry will own.
- R3: At issue, an operand whose tag is 0 is stored as a present value. An operand with a non-zero tag is held as a wait on that tag, and its value input is ignored.
- R4: A waiting operand takes `cdb_val` at the edge where `cdb_valid` is 1 and `cdb_tag` equals the tag it waits on. If that was its last missing operand, the station can dispatch in the following cycle.
- R5: If the broadcast bus carries a tag at the same edge as an issue that waits on that tag, the new entry takes the broadcast value at once and does not wait.
- R6: `disp_valid` is 1 in a cycle exactly when some occupied station has both operands present and has not yet been dispatched. Each station is dispatched once, and `disp_op`, `disp_vj` and `disp_vk` carry its stored operation and values.
- R7: When several stations are ready, the one accepted at the earliest issue is dispatched first, whatever its slot index. `disp_tag` is BASE_TAG plus its slot index.
- R8: A dispatched station is freed at the edge where the broadcast bus carries its own tag. If its own tag is broadcast before it has been dispatched, it is not freed.
- R9: After reset all slots are free: `iss_full` and `disp_valid` are 0 and `iss_tag` equals BASE_TAG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued entry |
| iss_qj | input | TAG_W | Producer tag of the first operand, 0 if the value is present |
| iss_vj | input | DATA_W | First operand value, used when `iss_qj` is 0 |
| iss_qk | input | TAG_W | Producer tag of the second operand, 0 if the value is present |
| iss_vk | input | DATA_W | Second operand value, used when `iss_qk` is 0 |
| iss_full | output | 1 | No free station, so issue stalls |
| iss_tag | output | TAG_W | Tag that the next accepted entry will own |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_val | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | An entry is sent to the unit this cycle |
| disp_op | output | OP_W | Operation of the dispatched entry |
| disp_vj | output | DATA_W | First operand value of the dispatched entry |
| disp_vk | output | DATA_W | Second operand value of the dispatched entry |
| disp_tag | output | TAG_W | Tag of the dispatched entry |

## Verification
An issue, a capture or a release takes effect at the rising edge that samples it. `iss_full` and `iss_tag` reflect it from just after that edge. The dispatch outputs are driven combinationally from registered station state, so a station whose last operand arrives at edge t is offered in the cycle after t. It is marked dispatched at the next edge. The bench drives inputs and samples outputs at the falling edge. Before each rising edge it advances a behavioural model, built from an age-ordered queue and integer arrays, by one step and compares every output in every cycle. As a result each result is checked in exactly the cycle in which it falls due.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_HOLD = 2'd1,
    ST_EXEC = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [DATA_W-1:0] load_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  output logic [TAG_W-1:0]  q,
  output logic [DATA_W-1:0] v
);
  logic [TAG_W-1:0]  q_q, q_d;
  logic [DATA_W-1:0] v_q, v_d;
  logic              ld_hit, snoop_hit, upd_en;

  assign ld_hit    = cdb_valid && (load_tag != '0) && (cdb_tag == load_tag);
  assign snoop_hit = cdb_valid && (q_q != '0) && (cdb_tag == q_q);
  assign upd_en    = load || snoop_hit;

  always_comb begin
    q_d = q_q;
    v_d = v_q;
    if (load) begin
      if (ld_hit) begin
        q_d = '0;
        v_d = cdb_val;
      end else begin
        q_d = load_tag;
        v_d = load_val;
      end
    end else if (snoop_hit) begin
      q_d = '0;
      v_d = cdb_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else if (upd_en) q_q <= q_d;
  end

  always_ff @(posedge clk) begin
    if (upd_en) v_q <= v_d;
  end

  assign q = q_q;
  assign v = v_q;

  // R4: a waiting operand captures the matching broadcast
  assert_snoop_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cdb_valid && q_q != '0 && cdb_tag == q_q) |=> (q_q == '0 && v_q == $past(cdb_val)))
    else $error("operand missed matching broadcast");

  // R5: issue in the same cycle as the producing broadcast
  assert_issue_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cdb_valid && load_tag != '0 && cdb_tag == load_tag) |=> (q_q == '0 && v_q == $past(cdb_val)))
    else $error("issue-time broadcast not captured");
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  input  logic              grant,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  rs_state_e        st_q, st_d;
  logic [OP_W-1:0]  op_q;
  logic [TAG_W-1:0] qj, qk;
  logic             own_bcast;

  assign own_bcast = cdb_valid && (cdb_tag == TAG_W'(MY_TAG));

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opj (
    .clk(clk), .rst_n(rst_n), .load(alloc_we), .load_tag(iss_qj), .load_val(iss_vj),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val), .q(qj), .v(vj));

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opk (
    .clk(clk), .rst_n(rst_n), .load(alloc_we), .load_tag(iss_qk), .load_val(iss_vk),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val), .q(qk), .v(vk));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FREE: if (alloc_we) st_d = ST_HOLD;
      ST_HOLD: if (grant)    st_d = ST_EXEC;
      ST_EXEC: if (own_bcast) st_d = ST_FREE;
      default: st_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FREE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (alloc_we) op_q <= iss_op;
  end

  assign busy  = (st_q != ST_FREE);
  assign ready = (st_q == ST_HOLD) && (qj == '0) && (qk == '0);
  assign op    = op_q;

  // R1: the allocator only writes into a free slot
  assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> (st_q == ST_FREE))
    else $error("allocation into an occupied station");

  // R6: only a station with both operands present is granted
  assert_disp_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (st_q == ST_HOLD && qj == '0 && qk == '0))
    else $error("grant to a station that is not ready");

  // R8: own tag frees a dispatched station
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC && own_bcast) |=> (st_q == ST_FREE))
    else $error("dispatched station not freed by its own tag");

  // R8: own tag before dispatch keeps the station
  assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |=> (st_q != ST_FREE))
    else $error("undispatched station freed");
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     free_vec,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (free_vec[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end

  // R2: at most one slot picked, and one is picked when any is free
  always_comb begin
    assert_alloc_onehot_R2: assert ($onehot0(grant))
      else $error("allocator picked several slots");
    assert_alloc_live_R2: assert (!(|free_vec) || (|grant))
      else $error("allocator picked nothing with a free slot");
  end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_we,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // older_q[r][c] == 1 : entry r was issued before entry c
  logic [N-1:0][N-1:0] older_q, older_d;
  logic [N-1:0][N-1:0] col;
  logic                mat_en;

  assign mat_en = |alloc_we;

  always_comb begin
    older_d = older_q;
    for (int n = 0; n < N; n++) begin
      if (alloc_we[n]) begin
        older_d[n] = '0;
        for (int r = 0; r < N; r++) begin
          if (r != n) older_d[r][n] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      older_q <= '0;
    else if (mat_en) older_q <= older_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_col
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign col[i][j] = older_q[j][i];
    end
    assign grant[i] = req[i] && !(|(req & col[i]));
  end

  // R7: one winner, and a ready station is never left without a winner
  assert_pick_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant))
    else $error("several stations granted");
  assert_pick_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|grant))
    else $error("ready stations but no grant");
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
  parameter int NUM_RS   = 4,
  parameter int OP_W     = 4,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  parameter int BASE_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic [DATA_W-1:0] iss_vk,
  output logic              iss_full,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_vj,
  output logic [DATA_W-1:0] disp_vk,
  output logic [TAG_W-1:0]  disp_tag
);
  localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

  logic [NUM_RS-1:0] busy_vec, ready_vec, free_vec;
  logic [NUM_RS-1:0] alloc_sel, alloc_we, pick;
  logic              alloc_any, issue_fire;
  logic [IDX_W-1:0]  alloc_idx, pick_idx;
  logic [OP_W-1:0]   ent_op [NUM_RS];
  logic [DATA_W-1:0] ent_vj [NUM_RS];
  logic [DATA_W-1:0] ent_vk [NUM_RS];

  assign free_vec   = ~busy_vec;
  assign iss_full   = ~alloc_any;
  assign issue_fire = iss_valid && alloc_any;
  assign alloc_we   = alloc_sel & {NUM_RS{issue_fire}};
  assign iss_tag    = TAG_W'(BASE_TAG) + TAG_W'(alloc_idx);

  rs_alloc #(.N(NUM_RS), .IDX_W(IDX_W)) u_alloc (
    .free_vec(free_vec), .grant(alloc_sel), .any(alloc_any), .idx(alloc_idx));

  rs_age_pick #(.N(NUM_RS)) u_pick (
    .clk(clk), .rst_n(rst_n), .alloc_we(alloc_we), .req(ready_vec), .grant(pick));

  for (genvar i = 0; i < NUM_RS; i++) begin : g_ent
    rs_entry #(
      .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(BASE_TAG + i)
    ) u_ent (
      .clk(clk), .rst_n(rst_n), .alloc_we(alloc_we[i]),
      .iss_op(iss_op), .iss_qj(iss_qj), .iss_vj(iss_vj), .iss_qk(iss_qk), .iss_vk(iss_vk),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
      .grant(pick[i]), .busy(busy_vec[i]), .ready(ready_vec[i]),
      .op(ent_op[i]), .vj(ent_vj[i]), .vk(ent_vk[i]));
  end

  always_comb begin
    disp_op  = '0;
    disp_vj  = '0;
    disp_vk  = '0;
    pick_idx = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (pick[i]) begin
        disp_op  = disp_op | ent_op[i];
        disp_vj  = disp_vj | ent_vj[i];
        disp_vk  = disp_vk | ent_vk[i];
        pick_idx = pick_idx | IDX_W'(i);
      end
    end
  end

  assign disp_valid = |pick;
  assign disp_tag   = TAG_W'(BASE_TAG) + TAG_W'(pick_idx);

  // R1: a request while full leaves occupancy unable to grow
  assert_full_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_full) |=> ($countones(busy_vec) <= $countones($past(busy_vec))))
    else $error("occupancy grew while full");
endmodule

// File: tb/rs_bank_tb_top.sv
`timescale 1ns/1ps
module rs_bank_tb_top;
  localparam int N  = 4;
  localparam int OW = 4;
  localparam int DW = 32;
  localparam int TW = 3;
  localparam int BT = 1;

  logic          clk;
  logic          rst_n;
  logic          iss_valid;
  logic [OW-1:0] iss_op;
  logic [TW-1:0] iss_qj, iss_qk;
  logic [DW-1:0] iss_vj, iss_vk;
  logic          iss_full;
  logic [TW-1:0] iss_tag;
  logic          cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_val;
  logic          disp_valid;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_vj, disp_vk;
  logic [TW-1:0] disp_tag;

  rs_bank #(.NUM_RS(N), .OP_W(OW), .DATA_W(DW), .TAG_W(TW), .BASE_TAG(BT)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_qj(iss_qj), .iss_vj(iss_vj), .iss_qk(iss_qk), .iss_vk(iss_vk),
    .iss_full(iss_full), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_vj(disp_vj),
    .disp_vk(disp_vk), .disp_tag(disp_tag));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural model: 0 free, 1 waiting/ready, 2 dispatched
  int          m_st [N];
  int          m_op [N];
  int          m_qj [N];
  int          m_qk [N];
  logic [DW-1:0] m_vj [N];
  logic [DW-1:0] m_vk [N];
  int          ord [$];
  int          n_run, n_fail;

  task automatic chk(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int s = 0; s < N; s++) if (m_st[s] == 0) return s;
    return -1;
  endfunction

  function automatic int oldest_ready();
    foreach (ord[x]) begin
      int s = ord[x];
      if (m_st[s] == 1 && m_qj[s] == 0 && m_qk[s] == 0) return s;
    end
    return -1;
  endfunction

  task automatic compare_outputs();
    int lf = lowest_free();
    int p  = oldest_ready();
    chk("R1 iss_full", iss_full, (lf < 0) ? 1 : 0);
    if (lf >= 0) chk("R2 iss_tag", iss_tag, BT + lf);
    chk("R6 disp_valid", disp_valid, (p >= 0) ? 1 : 0);
    if (p >= 0) begin
      chk("R7 disp_tag", disp_tag, BT + p);
      chk("R6 disp_op", disp_op, m_op[p]);
      chk("R3 R4 disp_vj", disp_vj, m_vj[p]);
      chk("R3 R4 disp_vk", disp_vk, m_vk[p]);
    end
  endtask

  task automatic model_step();
    int lf = lowest_free();
    int p  = oldest_ready();
    bit rel [N];
    for (int s = 0; s < N; s++)
      rel[s] = (m_st[s] == 2) && cdb_valid && (int'(cdb_tag) == BT + s);
    for (int s = 0; s < N; s++) begin
      if (m_st[s] == 1 && cdb_valid) begin
        if (m_qj[s] != 0 && int'(cdb_tag) == m_qj[s]) begin m_qj[s] = 0; m_vj[s] = cdb_val; end
        if (m_qk[s] != 0 && int'(cdb_tag) == m_qk[s]) begin m_qk[s] = 0; m_vk[s] = cdb_val; end
      end
    end
    if (p >= 0) m_st[p] = 2;
    for (int s = 0; s < N; s++) begin
      if (rel[s]) begin
        m_st[s] = 0;
        for (int x = 0; x < ord.size(); x++) if (ord[x] == s) begin ord.delete(x); break; end
      end
    end
    if (iss_valid && lf >= 0) begin
      m_st[lf] = 1;
      m_op[lf] = int'(iss_op);
      if (iss_qj != 0 && cdb_valid && cdb_tag == iss_qj) begin m_qj[lf] = 0; m_vj[lf] = cdb_val; end
      else begin m_qj[lf] = int'(iss_qj); m_vj[lf] = iss_vj; end
      if (iss_qk != 0 && cdb_valid && cdb_tag == iss_qk) begin m_qk[lf] = 0; m_vk[lf] = cdb_val; end
      else begin m_qk[lf] = int'(iss_qk); m_vk[lf] = iss_vk; end
      ord.push_back(lf);
    end
  endtask

  // inputs are set at a falling edge before this is called
  task automatic cyc();
    compare_outputs();
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(bit iv, int op, int qj, int vj, int qk, int vk, bit cv, int ct, int cval);
    iss_valid = iv;     iss_op = OW'(op);
    iss_qj = TW'(qj);   iss_vj = DW'(vj);
    iss_qk = TW'(qk);   iss_vk = DW'(vk);
    cdb_valid = cv;     cdb_tag = TW'(ct);  cdb_val = DW'(cval);
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ta;
    n_run = 0;
    n_fail = 0;
    for (int s = 0; s < N; s++) begin
      m_st[s] = 0; m_op[s] = 0; m_qj[s] = 0; m_qk[s] = 0; m_vj[s] = '0; m_vk[s] = '0;
    end
    rst_n = 1'b0;
    iss_valid = 0; iss_op = '0; iss_qj = '0; iss_vj = '0; iss_qk = '0; iss_vk = '0;
    cdb_valid = 0; cdb_tag = '0; cdb_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk("R9 reset iss_full", iss_full, 0);
    chk("R9 reset disp_valid", disp_valid, 0);
    chk("R9 reset iss_tag", iss_tag, BT);

    // R3 R6: both values present, dispatch next cycle, R8 release on own tag
    drive(1, 3, 0, 10, 0, 20, 0, 0, 0);
    idle(1);
    drive(0, 0, 0, 0, 0, 0, 1, 1, 30);
    idle(1);

    // R5: issue waiting on tag 5 while tag 5 is broadcast
    drive(1, 5, 5, 999, 0, 1, 1, 5, 77);
    idle(2);
    drive(0, 0, 0, 0, 0, 0, 1, BT, 0);

    // R4: chain, B waits on A's tag
    ta = int'(iss_tag);
    drive(1, 1, 6, 0, 0, 2, 0, 0, 0);
    drive(1, 2, ta, 0, 0, 4, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 6, 40);
    idle(1);
    drive(0, 0, 0, 0, 0, 0, 1, ta, 99);
    idle(2);
    for (int s = 0; s < N; s++) drive(0, 0, 0, 0, 0, 0, 1, BT + s, 0);

    // R1: fill every slot, then request while full
    for (int i = 0; i < N; i++) drive(1, 8 + i, 7, 0, 0, i, 0, 0, 0);
    drive(1, 15, 0, 5, 0, 6, 0, 0, 0);
    drive(1, 14, 0, 5, 0, 6, 0, 0, 0);
    // R8: own tag while still waiting must not free it
    drive(0, 0, 0, 0, 0, 0, 1, BT + 1, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 7, 123);
    idle(N + 1);
    for (int s = 0; s < N; s++) drive(0, 0, 0, 0, 0, 0, 1, BT + s, 0);

    // R7: older station in a higher slot wins over a reused lower slot
    drive(1, 1, 5, 0, 0, 0, 0, 0, 0);
    drive(1, 2, 7, 0, 0, 0, 0, 0, 0);
    drive(1, 3, 7, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 5, 11);
    idle(1);
    drive(0, 0, 0, 0, 0, 0, 1, BT, 0);
    drive(1, 4, 7, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 7, 22);
    idle(4);
    for (int s = 0; s < N; s++) drive(0, 0, 0, 0, 0, 0, 1, BT + s, 0);

    // mixed traffic covering R1 to R8 together
    for (int i = 0; i < 600; i++) begin
      int qj = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, 7));
      int qk = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, 7));
      drive($urandom_range(0, 1), int'($urandom_range(0, 15)), qj, int'($urandom()),
            qk, int'($urandom()), $urandom_range(0, 1), int'($urandom_range(1, 7)),
            int'($urandom()));
    end
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule